// File: doc/BRIEF.md
# Pipelined Fixed-Point Reciprocal

This block returns 1/x for a signed 32-bit two's-complement operand with 16 fractional bits (Q15.16). The result uses the same format. No divider is used. The magnitude of x is normalised into [1,2) by shifting its leading one to the top. A reciprocal curve is built at elaboration and indexed by the upper mantissa bits. The block then interpolates linearly between the two neighbouring curve points, using the mantissa bits below the index as the weight. Last, it reverses the normalising shift, rounds, saturates and applies the sign of x.

Operands enter and results leave on valid/ready streams. An operand transfers on a rising edge where `in_valid` and `in_ready` are both high. A result transfers on an edge where `out_valid` and `out_ready` are both high. All four pipeline stages advance together whenever the output register is empty or is being drained. While a result waits with `out_ready` low, the whole pipeline freezes and `in_ready` drops. This means `in_ready` depends on `out_ready` in the same cycle. A zero operand gives the most positive code and raises `div_by_zero` alongside that result.

Top module: `recip_q16`

## Requirements
- R1: While a synchronous reset (`rst` high) is applied, and after it is released, `out_valid` is low and `in_ready` is high until a result is produced.
- R2: Bit 16 of x and y weighs 1.0. An operand of 0x0001_0000 (1.0) gives 0x0001_0000. An operand of 0x0002_0000 (2.0) gives 0x0000_8000 (0.5). An operand of 0xFFFE_0000 (-2.0) gives 0xFFFF_8000 (-0.5).
- R3: For |x| >= 1.0, y lies within 2 LSB of 2^32/x. For smaller non-saturating magnitudes, y lies within 2 LSB plus 0.004 % of that value.
- R4: The result for -x is the exact two's-complement negation of the result for x whenever neither result saturates. A nonzero negative operand always gives a negative y, and a positive operand never does.
- R5: An operand of 0 gives y = 0x7FFF_FFFF with `div_by_zero` high in the same output cycle. For any nonzero operand, `div_by_zero` is low.
- R6: A result whose magnitude does not fit saturates, and never wraps. A positive overflow gives 0x7FFF_FFFF. A negative overflow gives 0x8000_0000. Raw operand 0x0000_0002 gives 0x7FFF_FFFF. Raw operand 0xFFFF_FFFE gives exactly 0x8000_0000, which is representable.
- R7: With `out_ready` held high, an operand accepted at the edge ending cycle c appears with `out_valid` high in cycle c+4. One operand is accepted per cycle, and results leave in acceptance order.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `y` and `div_by_zero` hold steady. An operand offered during that time is not taken until the stall clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| x | input | 32 | Signed Q15.16 operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| y | output | 32 | Signed Q15.16 reciprocal |
| div_by_zero | output | 1 | Result came from a zero operand |

## Verification
Back-pressure and operand arrival can fall in the same cycle. The bench holds `out_ready` low while it keeps offering a fourth operand to a full pipeline. It judges that `in_ready` stays low and that `y` does not move. It then releases the stall in the same cycle as the pending offer, and judges that all four results come out in order with exact values. A second overlap occurs when a zero operand streams back-to-back between nonzero ones. The bench checks that the flag stays with its own result and does not leak onto the neighbouring results.

// File: rtl/recip_pkg.sv
package recip_pkg;

  // Rounded curve point (2^tfrac) / (1 + k/2^idx_bits), computed at elaboration.
  function automatic longint unsigned recip_point(input int k, input int idx_bits, input int tfrac);
    longint unsigned num;
    longint unsigned den;
    den = (64'd1 << idx_bits) + 64'(k);
    num = 64'd1 << (tfrac + idx_bits);
    return (num + den / 2) / den;
  endfunction

endpackage

// File: rtl/recip_norm.sv
module recip_norm #(
  parameter int DW   = 32,
  parameter int PW   = 5,
  parameter int KEEP = 23
) (
  input  logic [DW-1:0]   x,
  output logic            neg,
  output logic            zero,
  output logic [PW-1:0]   pos,
  output logic [KEEP-1:0] frac
);
  logic [DW-1:0] mag;

  always_comb begin
    neg  = x[DW-1];
    mag  = neg ? (~x + 1'b1) : x;
    zero = (mag == '0);
    pos  = '0;
    for (int i = 0; i < DW; i++) begin
      if (mag[i]) pos = PW'(i);
    end
    // leading one moved to bit DW-1, then the bits right below it are kept
    frac = KEEP'((mag << (PW'(DW - 1) - pos)) >> (DW - 1 - KEEP));
  end
endmodule

// File: rtl/recip_table.sv
module recip_table #(
  parameter int IDX_BITS = 7,
  parameter int WBITS    = 16,
  parameter int TFRAC    = 18,
  parameter int TW       = TFRAC + 1
) (
  input  logic [IDX_BITS+WBITS-1:0] frac,
  output logic [TW-1:0]             base,
  output logic [TW-1:0]             step,
  output logic [WBITS-1:0]          wt
);
  import recip_pkg::*;
  localparam int N = 1 << IDX_BITS;

  logic [TW-1:0]       tbl [0:N];
  logic [IDX_BITS:0]   idx;
  logic [IDX_BITS:0]   nxt;

  for (genvar k = 0; k <= N; k++) begin : g_pt
    assign tbl[k] = TW'(recip_point(k, IDX_BITS, TFRAC));
  end

  always_comb begin
    idx  = {1'b0, frac[IDX_BITS+WBITS-1 -: IDX_BITS]};
    nxt  = idx + 1'b1;
    wt   = frac[WBITS-1:0];
    base = tbl[idx];
    step = tbl[idx] - tbl[nxt];
  end
endmodule

// File: rtl/recip_blend.sv
module recip_blend #(
  parameter int TW    = 19,
  parameter int WBITS = 16
) (
  input  logic [TW-1:0]    base,
  input  logic [TW-1:0]    step,
  input  logic [WBITS-1:0] wt,
  output logic [TW-1:0]    recip
);
  localparam int PWD = TW + WBITS;
  localparam logic [PWD-1:0] HALF = PWD'(1) << (WBITS - 1);

  logic [PWD-1:0] prod;
  logic [PWD-1:0] corr;

  always_comb begin
    prod  = {{WBITS{1'b0}}, step} * {{TW{1'b0}}, wt};
    corr  = (prod + HALF) >> WBITS;
    recip = base - TW'(corr);
  end
endmodule

// File: rtl/recip_denorm.sv
module recip_denorm #(
  parameter int DW    = 32,
  parameter int FW    = 16,
  parameter int TFRAC = 18,
  parameter int TW    = TFRAC + 1,
  parameter int PW    = 5
) (
  input  logic [TW-1:0] recip,
  input  logic [PW-1:0] pos,
  input  logic          neg,
  input  logic          zero,
  output logic [DW-1:0] y,
  output logic          dbz
);
  localparam int SH = 2 * FW - TFRAC;
  localparam int WW = TW + SH + 1;
  localparam logic [WW-1:0] POSMAX = (WW'(1) << (DW - 1)) - 1'b1;
  localparam logic [WW-1:0] NEGMAX = WW'(1) << (DW - 1);

  logic [WW-1:0] wide;
  logic [WW-1:0] rnd;
  logic [WW-1:0] mag;

  always_comb begin
    wide = {1'b0, recip, {SH{1'b0}}};
    rnd  = (pos == '0) ? '0 : (WW'(1) << (pos - 1'b1));
    mag  = (wide + rnd) >> pos;
    dbz  = zero;
    if (zero)
      y = POSMAX[DW-1:0];
    else if (!neg)
      y = (mag > POSMAX) ? POSMAX[DW-1:0] : mag[DW-1:0];
    else
      y = (mag > NEGMAX) ? NEGMAX[DW-1:0] : (~mag[DW-1:0] + 1'b1);
  end
endmodule

// File: rtl/recip_q16.sv
module recip_q16 #(
  parameter int DW       = 32,
  parameter int FW       = 16,
  parameter int IDX_BITS = 7,
  parameter int WBITS    = 16,
  parameter int TFRAC    = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] x,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] y,
  output logic          div_by_zero
);
  localparam int PW   = $clog2(DW);
  localparam int KEEP = IDX_BITS + WBITS;
  localparam int TW   = TFRAC + 1;

  logic advance;

  // stage 1: normalised operand
  logic            v1, n1, z1;
  logic [PW-1:0]   p1;
  logic [KEEP-1:0] f1;
  logic            n1_d, z1_d;
  logic [PW-1:0]   p1_d;
  logic [KEEP-1:0] f1_d;

  // stage 2: curve points and weight
  logic             v2, n2, z2;
  logic [PW-1:0]    p2;
  logic [TW-1:0]    b2, s2;
  logic [WBITS-1:0] w2;
  logic [TW-1:0]    b2_d, s2_d;
  logic [WBITS-1:0] w2_d;

  // stage 3: interpolated reciprocal of the mantissa
  logic          v3, n3, z3;
  logic [PW-1:0] p3;
  logic [TW-1:0] r3, r3_d;

  // stage 4: output register
  logic [DW-1:0] y_d;
  logic          dbz_d;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  recip_norm #(.DW(DW), .PW(PW), .KEEP(KEEP)) u_norm (
    .x(x), .neg(n1_d), .zero(z1_d), .pos(p1_d), .frac(f1_d)
  );

  recip_table #(.IDX_BITS(IDX_BITS), .WBITS(WBITS), .TFRAC(TFRAC), .TW(TW)) u_table (
    .frac(f1), .base(b2_d), .step(s2_d), .wt(w2_d)
  );

  recip_blend #(.TW(TW), .WBITS(WBITS)) u_blend (
    .base(b2), .step(s2), .wt(w2), .recip(r3_d)
  );

  recip_denorm #(.DW(DW), .FW(FW), .TFRAC(TFRAC), .TW(TW), .PW(PW)) u_denorm (
    .recip(r3), .pos(p3), .neg(n3), .zero(z3), .y(y_d), .dbz(dbz_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      out_valid   <= 1'b0;
      y           <= '0;
      div_by_zero <= 1'b0;
      n1 <= 1'b0; z1 <= 1'b0; p1 <= '0; f1 <= '0;
      n2 <= 1'b0; z2 <= 1'b0; p2 <= '0; b2 <= '0; s2 <= '0; w2 <= '0;
      n3 <= 1'b0; z3 <= 1'b0; p3 <= '0; r3 <= '0;
    end else if (advance) begin
      v1 <= in_valid;
      n1 <= n1_d; z1 <= z1_d; p1 <= p1_d; f1 <= f1_d;
      v2 <= v1;
      n2 <= n1; z2 <= z1; p2 <= p1; b2 <= b2_d; s2 <= s2_d; w2 <= w2_d;
      v3 <= v2;
      n3 <= n2; z3 <= z2; p3 <= p2; r3 <= r3_d;
      out_valid   <= v3;
      y           <= y_d;
      div_by_zero <= dbz_d && v3;
    end
  end
endmodule

// File: rtl/recip_q16_chk.sv
module recip_q16_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] x,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] y,
  input logic          div_by_zero
);
  logic [3:0] sv, sz, sn;

  always_ff @(posedge clk) begin
    if (rst) begin
      sv <= '0; sz <= '0; sn <= '0;
    end else if (!out_valid || out_ready) begin
      sv <= {sv[2:0], in_valid && in_ready};
      sz <= {sz[2:0], x == '0};
      sn <= {sn[2:0], x[DW-1]};
    end
  end

  // R7
  lat_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == sv[3]);

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (div_by_zero == sz[3]));

  // R5
  zero_value_chk: assert property (@(posedge clk) disable iff (rst)
    div_by_zero |-> (out_valid && y == {1'b0, {(DW-1){1'b1}}}));

  // R4
  sign_match_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !sz[3]) |-> (y[DW-1] == sn[3]));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(y) && $stable(div_by_zero)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind recip_q16 recip_q16_chk #(.DW(DW)) u_chk (.*);

// File: tb/recip_q16_bench.sv
module recip_q16_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] x = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] y;
  logic        div_by_zero;
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;

  always #10 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;

  recip_q16 u_recip_q16 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .x(x),
    .out_valid(out_valid), .out_ready(out_ready), .y(y), .div_by_zero(div_by_zero)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_near(input string tag, input logic [31:0] xin, input logic [31:0] act, input real rel);
    real rf, er, tol;
    rf  = 4294967296.0 / $itor($signed(xin));
    er  = $itor($signed(act)) - rf;
    tol = 2.0 + rel * (rf < 0.0 ? -rf : rf);
    total++;
    if (er > tol || er < -tol) begin
      bad++;
      $display("FAIL %s x=%h actual=%h expected=%f", tag, xin, act, rf);
    end
  endtask

  // one operand in, waits for its result; lat counts edges from acceptance
  task automatic send_one(input logic [31:0] v, output logic [31:0] r, output logic f, output int lat);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    x         = v;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    r = y;
    f = div_by_zero;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R1 out_valid in reset", {31'b0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 out_valid after reset", {31'b0, out_valid}, 32'd0);
    check_eq("R1 in_ready after reset", {31'b0, in_ready}, 32'd1);
  endtask

  task automatic t_format();
    logic [31:0] r; logic f; int lat;
    send_one(32'h0001_0000, r, f, lat);
    check_eq("R2 1.0", r, 32'h0001_0000);
    check_eq("R5 no flag on nonzero", {31'b0, f}, 32'd0);
    check_eq("R7 latency", 32'(lat), 32'd4);
    send_one(32'h0002_0000, r, f, lat);
    check_eq("R2 2.0", r, 32'h0000_8000);
    send_one(32'hFFFE_0000, r, f, lat);
    check_eq("R2 -2.0", r, 32'hFFFF_8000);
  endtask

  task automatic t_accuracy();
    logic [31:0] r, v; logic f; int lat;
    for (int i = 0; i < 150; i++) begin
      int e;
      e = 16 + (i % 15);
      v = (32'd1 << e) | ($urandom() & ((32'd1 << e) - 1));
      if (i[4]) v = ~v + 1'b1;
      send_one(v, r, f, lat);
      check_near("R3 large operand", v, r, 0.0);
    end
    for (int i = 0; i < 60; i++) begin
      int e;
      real rf;
      e = 2 + (i % 14);
      v = (32'd1 << e) | ($urandom() & ((32'd1 << e) - 1));
      if (i[2]) v = ~v + 1'b1;
      rf = 4294967296.0 / $itor($signed(v));
      if (rf < 0.0) rf = -rf;
      if (rf < 2.0e9) begin
        send_one(v, r, f, lat);
        check_near("R3 small operand", v, r, 0.00004);
      end
    end
  endtask

  task automatic t_sign();
    logic [31:0] rp, rn, v; logic f; int lat;
    for (int i = 0; i < 6; i++) begin
      v = 32'h0000_3000 + 32'(i) * 32'h0013_4567;
      send_one(v, rp, f, lat);
      send_one(~v + 1'b1, rn, f, lat);
      check_eq("R4 negation symmetry", rn, ~rp + 1'b1);
    end
  endtask

  task automatic t_zero();
    logic [31:0] r; logic f; int lat;
    send_one(32'h0, r, f, lat);
    check_eq("R5 zero value", r, 32'h7FFF_FFFF);
    check_eq("R5 zero flag", {31'b0, f}, 32'd1);
  endtask

  task automatic t_saturate();
    logic [31:0] r; logic f; int lat;
    send_one(32'h0000_0001, r, f, lat);
    check_eq("R6 positive overflow", r, 32'h7FFF_FFFF);
    check_eq("R6 no zero flag on overflow", {31'b0, f}, 32'd0);
    send_one(32'hFFFF_FFFF, r, f, lat);
    check_eq("R6 negative overflow", r, 32'h8000_0000);
    send_one(32'h0000_0002, r, f, lat);
    check_eq("R6 raw 2", r, 32'h7FFF_FFFF);
    send_one(32'hFFFF_FFFE, r, f, lat);
    check_eq("R6 raw -2 exact", r, 32'h8000_0000);
    send_one(32'h8000_0000, r, f, lat);
    check_eq("R6 most negative operand", r, 32'hFFFF_FFFE);
  endtask

  task automatic t_stream();
    logic [31:0] vin [8];
    logic [31:0] exp [8];
    int          acc [8];
    logic [31:0] got [8];
    logic        gf  [8];
    int          gc  [8];
    for (int j = 0; j < 8; j++) begin
      vin[j] = 32'h0001_0000 << j;
      exp[j] = 32'h0001_0000 >> j;
    end
    vin[3] = 32'h0; exp[3] = 32'h7FFF_FFFF;
    out_ready = 1'b1;
    fork
      begin
        for (int j = 0; j < 8; j++) begin
          @(negedge clk);
          in_valid = 1'b1;
          x = vin[j];
          acc[j] = cyc;
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        int n;
        n = 0;
        for (int k = 0; k < 20 && n < 8; k++) begin
          @(negedge clk);
          if (out_valid) begin
            got[n] = y; gf[n] = div_by_zero; gc[n] = cyc; n++;
          end
        end
      end
    join
    for (int j = 0; j < 8; j++) begin
      check_eq("R7 stream value", got[j], exp[j]);
      check_eq("R7 stream cycle", 32'(gc[j]), 32'(acc[j] + 4));
      check_eq("R5 flag only on zero", {31'b0, gf[j]}, (j == 3) ? 32'd1 : 32'd0);
    end
  endtask

  task automatic t_backpressure();
    logic [31:0] vin [4];
    logic [31:0] exp [4];
    logic [31:0] got [4];
    logic [31:0] held;
    int j, n;
    vin[0] = 32'h0001_0000; exp[0] = 32'h0001_0000;
    vin[1] = 32'h0004_0000; exp[1] = 32'h0000_4000;
    vin[2] = 32'hFFFE_0000; exp[2] = 32'hFFFF_8000;
    vin[3] = 32'h0008_0000; exp[3] = 32'h0000_2000;
    @(negedge clk);
    out_ready = 1'b0;
    j = 0;
    while (j < 3) begin
      logic smp;
      in_valid = 1'b1;
      x = vin[j];
      smp = in_ready;
      @(posedge clk);
      if (smp) j++;
      @(negedge clk);
    end
    x = vin[3];
    for (int k = 0; k < 10 && !out_valid; k++) @(negedge clk);
    held = y;
    got[0] = y;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check_eq("R8 in_ready low while stalled", {31'b0, in_ready}, 32'd0);
      check_eq("R8 y held while stalled", y, held);
    end
    out_ready = 1'b1;
    #1;
    check_eq("R8 in_ready on release", {31'b0, in_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 1;
    for (int k = 0; k < 10 && n < 4; k++) begin
      if (out_valid) begin
        got[n] = y; n++;
      end
      @(negedge clk);
    end
    for (int k = 0; k < 4; k++) check_eq("R8 order after stall", got[k], exp[k]);
  endtask

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_format();
    t_zero();
    t_saturate();
    t_sign();
    t_accuracy();
    t_stream();
    t_backpressure();
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule